// File: doc/BRIEF.md
# Multi-cycle 64-bit core for a small teaching instruction set

The block is a sequential, non-pipelined processor core. It executes fixed 32-bit instruction words and holds 256 registers of 64 bits each. Every instruction passes through a fetch phase and an execute phase. A byte load adds a third phase that waits on the data memory. The fetch phase uses a word-addressed instruction port with a request/valid handshake. Character input and output use plain valid/ready byte streams.

An instruction word carries its opcode in bits [31:24]. The other 24 bits are decoded in one of three ways. The three-register layout gives X = [23:16], Y = [15:8] and Z = [7:0]. The jump layout treats [23:0] as a signed offset counted in instruction words. The load-immediate layout gives a 16-bit value in [23:8] and the destination Z in [7:0]. The core runs add, subtract, multiply, load-immediate, byte load and relative jumps. Jumps test two status flags, zero (ZF) and carry (CF). The program counter counts words: it starts at word 0 and advances by one word per instruction. The core stops on a halt instruction, which reports an exit code. It also stops on any opcode it does not know, and then sets an illegal-instruction flag.

Top module: `tiny64_core`

## Requirements
- R1: After reset, halted and illegal are low, and the core requests instruction word 0.
- R2: Opcode 0x0E writes register X plus register Y into register Z. Opcode 0x0A writes the unsigned 8-bit X field plus register Y into Z. Opcode 0x05 writes register Y minus the X field into Z. All results are taken modulo 2^64.
- R3: Opcode 0x0B writes the low 64 bits of register X times register Y into register Z. Opcode 0x0F does the same with the unsigned X field in place of register X.
- R4: Every add, subtract or multiply sets ZF when its 64-bit result is zero. It sets CF on carry-out for an add, on borrow for a subtract, and on a nonzero upper 64-bit half of the product for a multiply. No other instruction changes either flag.
- R5: Opcode 0x08 writes bits [23:8] of the instruction, zero-extended, into register Z.
- R6: Opcode 0x09 reads the byte at the address held in register X and writes it zero-extended into register Z. The core holds dmem_req and dmem_addr steady until dmem_valid arrives, for any latency.
- R7: Opcode 0x04 always jumps. A taken jump moves to the current word address plus the sign-extended offset in bits [23:0], so it can go forward or backward. A jump that is not taken moves to the next word.
- R8: Opcode 0x06 jumps when ZF is 0 and opcode 0x07 jumps when ZF is 1. Opcode 0x0C jumps when ZF and CF are both 0. Opcode 0x0D jumps when CF is 1.
- R9: Register 0 always reads as zero. A write to register 0 has no effect.
- R10: Opcode 0x02 waits for in_valid. It then takes one byte and writes it zero-extended into register X.
- R11: Opcode 0x03 presents the low byte of register X on out_data. It holds out_valid and the data until out_ready is seen.
- R12: Opcode 0x01 raises halted and puts the low byte of register X on exit_code. After that the core makes no instruction request, and both outputs stay unchanged until reset.
- R13: Any other opcode raises halted and illegal, with exit_code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_req | output | 1 | Instruction word request |
| imem_addr | output | 30 | Word address of the requested instruction |
| imem_valid | input | 1 | Instruction word returned |
| imem_rdata | input | 32 | Instruction word |
| dmem_req | output | 1 | Byte read request |
| dmem_addr | output | 64 | Byte address |
| dmem_valid | input | 1 | Byte returned |
| dmem_rdata | input | 8 | Returned byte |
| in_valid | input | 1 | Input byte available |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Core takes the input byte |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Sink takes the output byte |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unknown opcode |
| exit_code | output | 8 | Low byte of the halt register |

## Verification
Two actions can land in the same execute cycle: the register-file write of a result, and a read of that same register, or of register 0, by the same instruction. The bench triggers this with a countdown loop that subtracts into its own source register. It also runs an add whose destination is register 0, followed by a print of register 0. A behavioural instruction-level model in the bench predicts every output byte and the halt code. The bench compares each byte at the moment it is handed over, while the bench stalls the output, input and data-memory handshakes in varying patterns.

// File: rtl/tiny64_pkg.sv
package tiny64_pkg;

    localparam int REG_AW = 8;

    localparam logic [7:0] OP_HALT = 8'h01;
    localparam logic [7:0] OP_GETC = 8'h02;
    localparam logic [7:0] OP_PUTC = 8'h03;
    localparam logic [7:0] OP_JMP  = 8'h04;
    localparam logic [7:0] OP_SUBI = 8'h05;
    localparam logic [7:0] OP_JNZ  = 8'h06;
    localparam logic [7:0] OP_JZ   = 8'h07;
    localparam logic [7:0] OP_LDW  = 8'h08;
    localparam logic [7:0] OP_LDB  = 8'h09;
    localparam logic [7:0] OP_ADDI = 8'h0A;
    localparam logic [7:0] OP_MULR = 8'h0B;
    localparam logic [7:0] OP_JA   = 8'h0C;
    localparam logic [7:0] OP_JB   = 8'h0D;
    localparam logic [7:0] OP_ADDR = 8'h0E;
    localparam logic [7:0] OP_MULI = 8'h0F;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_MUL
    } alu_op_e;

    typedef enum logic [1:0] {
        PH_FETCH,
        PH_EXEC,
        PH_LOAD,
        PH_STOP
    } phase_e;

endpackage

// File: rtl/tiny64_regfile.sv
module tiny64_regfile #(
    parameter int W  = 64,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    localparam int N = 1 << AW;

    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we && wa != '0) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

    // R9: a write to a nonzero register is visible on the next read of it
    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0) |=> (ra_a != $past(wa) || rd_a == $past(wd)));

    // R9: register 0 stays zero even right after a write aimed at it
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0) |=> (ra_b != '0 || rd_b == '0));

endmodule

// File: rtl/tiny64_alu.sv
module tiny64_alu
    import tiny64_pkg::*;
#(
    parameter int W = 64
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  res,
    output logic          zf,
    output logic          cf
);
    logic [W:0]     sum;
    logic [W:0]     diff;
    logic [2*W-1:0] prod;

    always_comb begin
        sum  = {1'b0, a} + {1'b0, b};
        diff = {1'b0, b} - {1'b0, a};
        prod = a * b;
        unique case (op)
            ALU_SUB: begin
                res = diff[W-1:0];
                cf  = diff[W];
            end
            ALU_MUL: begin
                res = prod[W-1:0];
                cf  = |prod[2*W-1:W];
            end
            default: begin
                res = sum[W-1:0];
                cf  = sum[W];
            end
        endcase
        zf = (res == '0);
    end

endmodule

// File: rtl/tiny64_core.sv
module tiny64_core
    import tiny64_pkg::*;
#(
    parameter int W    = 64,
    parameter int IA_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            imem_req,
    output logic [IA_W-1:0] imem_addr,
    input  logic            imem_valid,
    input  logic [31:0]     imem_rdata,
    output logic            dmem_req,
    output logic [W-1:0]    dmem_addr,
    input  logic            dmem_valid,
    input  logic [7:0]      dmem_rdata,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    output logic            out_valid,
    output logic [7:0]      out_data,
    input  logic            out_ready,
    output logic            halted,
    output logic            illegal,
    output logic [7:0]      exit_code
);
    localparam int OFF_W = 24;

    typedef struct packed {
        phase_e          ph;
        logic [IA_W-1:0] pc;
        logic [31:0]     ir;
        logic            zf;
        logic            cf;
        logic            ill;
        logic [7:0]      code;
    } core_s;

    core_s st_d, st_q;

    logic [7:0]        opc, fx, fy, fz;
    logic [15:0]       fxy;
    logic [IA_W-1:0]   pc_next, pc_jump;
    logic [W-1:0]      rd_a, rd_b;
    logic              rf_we;
    logic [REG_AW-1:0] rf_wa;
    logic [W-1:0]      rf_wd;
    alu_op_e           alu_op;
    logic [W-1:0]      alu_a, alu_res;
    logic              alu_zf, alu_cf;

    assign opc = st_q.ir[31:24];
    assign fx  = st_q.ir[23:16];
    assign fy  = st_q.ir[15:8];
    assign fz  = st_q.ir[7:0];
    assign fxy = st_q.ir[23:8];

    assign pc_next = st_q.pc + 1'b1;
    assign pc_jump = st_q.pc + {{(IA_W-OFF_W){st_q.ir[OFF_W-1]}}, st_q.ir[OFF_W-1:0]};

    tiny64_regfile #(.W(W), .AW(REG_AW)) rf_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ra_a (fx),
        .rd_a (rd_a),
        .ra_b (fy),
        .rd_b (rd_b),
        .we   (rf_we),
        .wa   (rf_wa),
        .wd   (rf_wd)
    );

    always_comb begin
        unique case (opc)
            OP_SUBI:          alu_op = ALU_SUB;
            OP_MULR, OP_MULI: alu_op = ALU_MUL;
            default:          alu_op = ALU_ADD;
        endcase
        alu_a = (opc == OP_ADDR || opc == OP_MULR) ? rd_a : {{(W-8){1'b0}}, fx};
    end

    tiny64_alu #(.W(W)) alu_i (
        .op (alu_op),
        .a  (alu_a),
        .b  (rd_b),
        .res(alu_res),
        .zf (alu_zf),
        .cf (alu_cf)
    );

    always_comb begin
        st_d  = st_q;
        rf_we = 1'b0;
        rf_wa = fz;
        rf_wd = alu_res;
        unique case (st_q.ph)
            PH_FETCH: begin
                if (imem_valid) begin
                    st_d.ir = imem_rdata;
                    st_d.ph = PH_EXEC;
                end
            end
            PH_EXEC: begin
                st_d.ph = PH_FETCH;
                st_d.pc = pc_next;
                unique case (opc)
                    OP_HALT: begin
                        st_d.ph   = PH_STOP;
                        st_d.pc   = st_q.pc;
                        st_d.code = rd_a[7:0];
                    end
                    OP_GETC: begin
                        if (in_valid) begin
                            rf_we = 1'b1;
                            rf_wa = fx;
                            rf_wd = {{(W-8){1'b0}}, in_data};
                        end else begin
                            st_d.ph = PH_EXEC;
                            st_d.pc = st_q.pc;
                        end
                    end
                    OP_PUTC: begin
                        if (!out_ready) begin
                            st_d.ph = PH_EXEC;
                            st_d.pc = st_q.pc;
                        end
                    end
                    OP_JMP: st_d.pc = pc_jump;
                    OP_JNZ: if (!st_q.zf) st_d.pc = pc_jump;
                    OP_JZ:  if (st_q.zf) st_d.pc = pc_jump;
                    OP_JA:  if (!st_q.zf && !st_q.cf) st_d.pc = pc_jump;
                    OP_JB:  if (st_q.cf) st_d.pc = pc_jump;
                    OP_SUBI, OP_ADDI, OP_ADDR, OP_MULR, OP_MULI: begin
                        rf_we   = 1'b1;
                        st_d.zf = alu_zf;
                        st_d.cf = alu_cf;
                    end
                    OP_LDW: begin
                        rf_we = 1'b1;
                        rf_wd = {{(W-16){1'b0}}, fxy};
                    end
                    OP_LDB: begin
                        st_d.ph = PH_LOAD;
                        st_d.pc = st_q.pc;
                    end
                    default: begin
                        st_d.ph   = PH_STOP;
                        st_d.pc   = st_q.pc;
                        st_d.ill  = 1'b1;
                        st_d.code = '0;
                    end
                endcase
            end
            PH_LOAD: begin
                if (dmem_valid) begin
                    rf_we   = 1'b1;
                    rf_wd   = {{(W-8){1'b0}}, dmem_rdata};
                    st_d.ph = PH_FETCH;
                    st_d.pc = pc_next;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_FETCH, pc: '0, ir: '0, zf: 1'b0, cf: 1'b0,
                      ill: 1'b0, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_req  = (st_q.ph == PH_FETCH);
    assign imem_addr = st_q.pc;
    assign dmem_req  = (st_q.ph == PH_LOAD);
    assign dmem_addr = rd_a;
    assign in_ready  = (st_q.ph == PH_EXEC) && (opc == OP_GETC);
    assign out_valid = (st_q.ph == PH_EXEC) && (opc == OP_PUTC);
    assign out_data  = rd_a[7:0];
    assign halted    = (st_q.ph == PH_STOP);
    assign illegal   = st_q.ill;
    assign exit_code = st_q.code;

    // R12: once stopped, stay stopped with a steady code and no fetch
    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(exit_code) && !imem_req));

    // R13: the illegal flag only appears on a stopped core
    p_illegal_halts_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);

    // R11: an unaccepted output byte is held unchanged
    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: a pending byte read keeps its request and address
    p_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_req && !dmem_valid) |=> (dmem_req && $stable(dmem_addr)));

    // R10: an unserved input wait keeps asking
    p_in_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);

endmodule

// File: tb/tiny64_core_tb.sv
`timescale 1ns/1ps
module tiny64_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_req;
    logic [29:0] imem_addr;
    logic        imem_valid = 1'b0;
    logic [31:0] imem_rdata = '0;
    logic        dmem_req;
    logic [63:0] dmem_addr;
    logic        dmem_valid = 1'b0;
    logic [7:0]  dmem_rdata = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        halted;
    logic        illegal;
    logic [7:0]  exit_code;

    always #2 clk = ~clk;

    tiny64_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_valid(imem_valid), .imem_rdata(imem_rdata),
        .dmem_req(dmem_req), .dmem_addr(dmem_addr),
        .dmem_valid(dmem_valid), .dmem_rdata(dmem_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .halted(halted), .illegal(illegal), .exit_code(exit_code)
    );

    logic [31:0] prog [64];
    int          wp;
    logic [7:0]  in_src [$];
    logic [7:0]  in_q [$];
    logic [7:0]  exp_q [$];
    int          checks = 0;
    int          errors = 0;
    string       cur_tag = "";
    int          igap = 0, dlat = 0, dcnt = 0, ocnt = 0;
    logic        in_fire = 1'b0, out_fire = 1'b0;
    logic [7:0]  out_cap = '0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] rrr(input logic [7:0] op, input logic [7:0] x,
                                        input logic [7:0] y, input logic [7:0] z);
        return {op, x, y, z};
    endfunction

    function automatic logic [31:0] jmp(input logic [7:0] op, input int off);
        logic [31:0] o;
        o = off;
        return {op, o[23:0]};
    endfunction

    function automatic logic [31:0] ldw(input logic [15:0] v, input logic [7:0] z);
        return {8'h08, v, z};
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[wp] = w;
        wp++;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = '0;
        wp = 0;
        in_src.delete();
    endtask

    // instruction-level reference model
    task automatic model_run(output logic [7:0] code, output logic ill);
        logic [63:0]  r [256];
        logic [7:0]   iq [$];
        int           pc;
        bit           zf, cf;
        logic [31:0]  w;
        logic [7:0]   op, x, y, z;
        int           off;
        logic [63:0]  rx, ry, res;
        logic [127:0] p;
        for (int i = 0; i < 256; i++) r[i] = '0;
        iq = in_src;
        exp_q.delete();
        pc = 0; zf = 0; cf = 0; code = '0; ill = 1'b0;
        for (int s = 0; s < 3000; s++) begin
            w = prog[pc % 64];
            op = w[31:24]; x = w[23:16]; y = w[15:8]; z = w[7:0];
            off = {{8{w[23]}}, w[23:0]};
            rx = r[x]; ry = r[y];
            case (op)
                8'h01: begin code = rx[7:0]; return; end
                8'h02: begin r[x] = {56'b0, iq.pop_front()}; pc++; end
                8'h03: begin exp_q.push_back(rx[7:0]); pc++; end
                8'h04: pc = pc + off;
                8'h05: begin res = ry - {56'b0, x}; zf = (res == 0); cf = (ry < {56'b0, x}); r[z] = res; pc++; end
                8'h06: pc = (!zf) ? pc + off : pc + 1;
                8'h07: pc = (zf) ? pc + off : pc + 1;
                8'h08: begin r[z] = {48'b0, w[23:8]}; pc++; end
                8'h09: begin r[z] = {56'b0, mem_byte(rx)}; pc++; end
                8'h0A: begin res = ry + {56'b0, x}; zf = (res == 0); cf = (res < ry); r[z] = res; pc++; end
                8'h0B: begin p = {64'b0, rx} * {64'b0, ry}; res = p[63:0]; zf = (res == 0); cf = (p[127:64] != 0); r[z] = res; pc++; end
                8'h0C: pc = (!zf && !cf) ? pc + off : pc + 1;
                8'h0D: pc = (cf) ? pc + off : pc + 1;
                8'h0E: begin res = rx + ry; zf = (res == 0); cf = (res < rx); r[z] = res; pc++; end
                8'h0F: begin p = {120'b0, x} * {64'b0, ry}; res = p[63:0]; zf = (res == 0); cf = (p[127:64] != 0); r[z] = res; pc++; end
                default: begin ill = 1'b1; code = '0; return; end
            endcase
            r[0] = '0;
        end
    endtask

    // memory, stream and output-monitor drivers; all changes at the falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            imem_valid = 1'b0; dmem_valid = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
            in_fire = 1'b0; out_fire = 1'b0; igap = 1; dlat = 0; dcnt = 0; ocnt = 0;
        end else begin
            if (in_fire) begin
                void'(in_q.pop_front());
                in_valid = 1'b0;
                igap = 2;
            end
            if (out_fire) begin
                if (exp_q.size() == 0) check({cur_tag, " R11 extra output"}, out_cap, 64'hx);
                else check({cur_tag, " R11 output byte"}, out_cap, exp_q.pop_front());
            end
            if (halted && imem_req) check("R12 fetch after halt", 1, 0);
            if (imem_req && !imem_valid) begin
                imem_valid = 1'b1;
                imem_rdata = prog[imem_addr % 64];
            end else imem_valid = 1'b0;
            if (dmem_req && !dmem_valid) begin
                if (dcnt == 0) begin
                    dmem_valid = 1'b1;
                    dmem_rdata = mem_byte(dmem_addr);
                    dlat = (dlat + 1) % 4;
                    dcnt = dlat;
                end else dcnt--;
            end else dmem_valid = 1'b0;
            if (!in_valid && in_q.size() > 0) begin
                if (igap == 0) begin in_valid = 1'b1; in_data = in_q[0]; end
                else igap--;
            end
            out_ready = (ocnt % 3) != 0;
            ocnt++;
            in_fire  = in_valid && in_ready;
            out_fire = out_valid && out_ready;
            out_cap  = out_data;
        end
    end

    task automatic run_prog(input string tag, input string htag);
        logic [7:0] mc;
        logic       mi;
        int         cyc;
        rst_n = 1'b0;
        cur_tag = tag;
        model_run(mc, mi);
        in_q = in_src;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check({tag, " R1 reset halted"}, halted, 0);
        check({tag, " R1 reset illegal"}, illegal, 0);
        check({tag, " R1 first fetch"}, {imem_req, 34'(imem_addr)}, {1'b1, 34'd0});
        cyc = 0;
        while (!halted && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 5000) check({tag, " R12 reached halt"}, 0, 1);
        repeat (3) @(negedge clk);
        check({htag, " exit code"}, exit_code, mc);
        check({htag, " illegal flag"}, illegal, mi);
        check({tag, " R11 outputs left over"}, exp_q.size(), 0);
        check("R12 halt sticky", halted, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // arithmetic, load-immediate and register 0: R2 R3 R5 R9
        clear_prog();
        emit(ldw(16'd200, 8'd1));
        emit(rrr(8'h0A, 8'd100, 8'd1, 8'd2));   // R2 immediate add
        emit(rrr(8'h03, 8'd2, 0, 0));
        emit(rrr(8'h05, 8'd5, 8'd2, 8'd3));     // R2 subtract immediate
        emit(rrr(8'h03, 8'd3, 0, 0));
        emit(rrr(8'h0B, 8'd2, 8'd3, 8'd4));     // R3 register multiply
        emit(rrr(8'h03, 8'd4, 0, 0));
        emit(rrr(8'h0F, 8'd7, 8'd1, 8'd5));     // R3 immediate multiply
        emit(rrr(8'h03, 8'd5, 0, 0));
        emit(rrr(8'h0E, 8'd1, 8'd2, 8'd0));     // R9 write to register 0
        emit(rrr(8'h03, 8'd0, 0, 0));
        emit(ldw(16'hABCD, 8'd6));              // R5
        emit(rrr(8'h03, 8'd6, 0, 0));
        emit(rrr(8'h0E, 8'd6, 8'd6, 8'd7));     // R2 register add
        emit(rrr(8'h03, 8'd7, 0, 0));
        emit(ldw(16'hFFFF, 8'd8));
        emit(rrr(8'h0B, 8'd8, 8'd8, 8'd9));
        emit(rrr(8'h0B, 8'd9, 8'd9, 8'd10));
        emit(rrr(8'h03, 8'd10, 0, 0));
        emit(rrr(8'h0E, 8'd10, 8'd10, 8'd11));  // R2 wrap modulo 2^64
        emit(rrr(8'h03, 8'd11, 0, 0));
        emit(rrr(8'h01, 8'd3, 0, 0));
        run_prog("R2 R3 R5 R9", "R12");

        // flags and jumps: R4 R7 R8
        clear_prog();
        emit(ldw(16'h00EE, 8'd9));
        emit(ldw(16'd3, 8'd1));
        emit(rrr(8'h03, 8'd1, 0, 0));
        emit(rrr(8'h05, 8'd1, 8'd1, 8'd1));     // source equals destination
        emit(jmp(8'h06, -2));                   // R7 backward jump
        emit(jmp(8'h07, 2));                    // R8 taken on ZF
        emit(rrr(8'h03, 8'd9, 0, 0));
        emit(rrr(8'h05, 8'd1, 8'd0, 8'd2));     // R4 borrow
        emit(jmp(8'h0D, 2));
        emit(rrr(8'h03, 8'd9, 0, 0));
        emit(rrr(8'h0A, 8'd1, 8'd0, 8'd3));
        emit(jmp(8'h0C, 2));
        emit(rrr(8'h03, 8'd9, 0, 0));
        emit(rrr(8'h0A, 8'd1, 8'd2, 8'd4));     // R4 carry and zero
        emit(jmp(8'h0C, 3));                    // R7 not taken
        emit(rrr(8'h03, 8'd2, 0, 0));
        emit(jmp(8'h0D, 2));
        emit(rrr(8'h03, 8'd9, 0, 0));
        emit(ldw(16'hFFFF, 8'd5));
        emit(rrr(8'h0B, 8'd5, 8'd5, 8'd6));
        emit(rrr(8'h0B, 8'd6, 8'd6, 8'd7));
        emit(rrr(8'h0B, 8'd7, 8'd5, 8'd8));     // R4 product overflow
        emit(jmp(8'h0D, 2));
        emit(rrr(8'h03, 8'd9, 0, 0));
        emit(jmp(8'h06, 2));
        emit(rrr(8'h03, 8'd9, 0, 0));
        emit(jmp(8'h04, 3));
        emit(rrr(8'h01, 8'd9, 0, 0));
        emit(jmp(8'h04, 2));
        emit(jmp(8'h04, -1));
        emit(rrr(8'h03, 8'd8, 0, 0));
        emit(rrr(8'h0A, 8'd0, 8'd0, 8'd12));    // ZF set, CF clear
        emit(jmp(8'h0C, 2));
        emit(rrr(8'h03, 8'd5, 0, 0));
        emit(rrr(8'h01, 8'd1, 0, 0));
        run_prog("R4 R7 R8", "R12");

        // input stream and byte loads: R6 R10
        clear_prog();
        in_src = '{8'h41, 8'hF3, 8'h07};
        emit(rrr(8'h02, 8'd1, 0, 0));
        emit(rrr(8'h03, 8'd1, 0, 0));
        emit(rrr(8'h02, 8'd2, 0, 0));
        emit(rrr(8'h09, 8'd2, 0, 8'd4));
        emit(rrr(8'h03, 8'd4, 0, 0));
        emit(ldw(16'h1234, 8'd5));
        emit(rrr(8'h09, 8'd5, 0, 8'd6));
        emit(rrr(8'h03, 8'd6, 0, 0));
        emit(rrr(8'h02, 8'd7, 0, 0));
        emit(rrr(8'h0A, 8'd200, 8'd7, 8'd8));
        emit(rrr(8'h03, 8'd8, 0, 0));
        emit(rrr(8'h05, 8'd1, 8'd2, 8'd9));     // zero-extension of an input byte
        emit(rrr(8'h03, 8'd9, 0, 0));
        emit(rrr(8'h01, 8'd4, 0, 0));
        run_prog("R6 R10", "R12");

        // unknown opcodes: R13
        clear_prog();
        emit(ldw(16'd7, 8'd1));
        emit(rrr(8'h03, 8'd1, 0, 0));
        emit(32'h0000_0000);
        run_prog("R13 zero opcode", "R13");

        clear_prog();
        emit(ldw(16'd9, 8'd3));
        emit(32'hFF12_3456);
        run_prog("R13 high opcode", "R13");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule